// File: doc/BRIEF.md
# Dataflow Graph Task Timing Network

This block models every task of a fixed-structure dataflow graph as a timing node, with the nodes wired together along the graph's edges. Each node is told where its task runs: the reconfigurable fabric, the master processor or the slave processor. It also receives the task's measured execution time. From the finish times of its predecessors the node works out the earliest start time of the task. It reports whether the task is waiting, ready, running or stopped. When the task completes, the node latches the start time and from then on presents a finish time.

Fabric tasks need no arbitration. They complete on the first clock edge after their dependencies clear, so independent fabric tasks complete together. Software tasks complete only when an external selector grants them and their processor is free. To help that selector break ties, each software node presents an urgency value derived from its downstream tasks that sit on other units. A task given a zero execution time counts as switched off. It passes through at once and adds no time, while the graph structure stays the same. The wrapper raises a completion flag once every node has finished and gives the largest finish time as the total length of the period.

Top module: `dft_graph`

## Requirements
- R1: Each task's unit is decoded from two flags: hw=1 selects the fabric whatever sw holds; hw=0 with sw=1 selects the master processor; hw=0 with sw=0 selects the slave processor.
- R2: A task's earliest start time equals the largest finish time among its predecessors, or 0 if it has none. On completion the start time is latched, finish time equals start time plus execution time, and the task stays done until reset.
- R3: A fabric task completes, with no grant, on the first clock edge at which all its predecessors are done. Fabric tasks whose dependencies clear together complete on the same edge.
- R4: An active software task completes only on an edge where its grant bit is high, all its predecessors are done and its processor's busy input is low. A grant that fails any of these conditions is ignored.
- R5: The state code per task is 0 waiting (a predecessor not done), 1 ready (dependencies done, software task, its processor busy), 2 running (dependencies done and able to issue) and 3 stopped (done). A fabric task never shows state 1.
- R6: A software task's urgency is the largest value over its successors. A successor on a different unit contributes its execution time. A successor on the same unit contributes its own urgency. Fabric tasks report urgency 0.
- R7: A task with execution time 0 completes like a fabric task, with no grant and regardless of processor busy. Its finish time equals its start time.
- R8: all_done is high exactly when every task is done, and total_time equals the largest finish time among done tasks.
- R9: A synchronous active-high reset clears every done flag and start time, so all_done and total_time read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_hw | input | N | Per-task fabric flag |
| task_sw | input | N | Per-task master/slave select |
| task_time | input | N*TW | Per-task execution time, task i at bits i*TW |
| task_grant | input | N | Issue grant from the external software selector |
| master_busy | input | 1 | Master processor is occupied |
| slave_busy | input | 1 | Slave processor is occupied |
| task_state | output | 2*N | Per-task state code, task i at bits 2*i |
| task_asap | output | N*TW | Per-task earliest start time |
| task_urgency | output | N*TW | Per-task urgency for tie-breaking |
| task_finish | output | N*TW | Per-task finish time (valid once done) |
| task_done | output | N | Per-task completion flag |
| all_done | output | 1 | Every task has completed |
| total_time | output | TW | Largest finish time of the period |

## Verification
Earliest start, urgency, state and finish are combinational on the inputs and on the latched done flags. The bench reads them one time unit after it changes an input and before the next rising edge. Completion is a single register stage: a fabric or zero-time task whose dependencies cleared, or a granted software task, shows done one edge later. A fabric successor that then becomes eligible completes on the edge after that. Each scenario therefore advances exactly one edge at a time, samples one unit past that edge, and compares done flags, finish times and the total against values computed by hand from the graph for that cycle.

// File: rtl/dft_pkg.sv
package dft_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_READY = 2'd1,
        ST_RUN   = 2'd2,
        ST_STOP  = 2'd3
    } task_state_e;

    typedef enum logic [1:0] {
        U_FABRIC = 2'd0,
        U_MASTER = 2'd1,
        U_SLAVE  = 2'd2
    } unit_e;

    // Two mapping flags select one of three execution units.
    function automatic unit_e unit_of(input logic hw, input logic sw);
        if (hw)
            return U_FABRIC;
        else if (sw)
            return U_MASTER;
        else
            return U_SLAVE;
    endfunction

endpackage

// File: rtl/dft_urgency.sv
module dft_urgency #(
    parameter int            N    = 4,
    parameter int            TW   = 16,
    parameter logic [N*N-1:0] PRED = 16'h6110
) (
    input  logic [N-1:0]    map_hw,
    input  logic [N-1:0]    map_sw,
    input  logic [N*TW-1:0] times,
    output logic [N*TW-1:0] urgency
);
    import dft_pkg::*;

    logic [TW-1:0] raw_v [N];

    // Successors always carry a higher index, so a backward sweep
    // sees every successor's value before it is needed.
    always_comb begin
        logic [TW-1:0] contrib;
        for (int i = N - 1; i >= 0; i--) begin
            raw_v[i] = '0;
            for (int j = 0; j < N; j++) begin
                contrib = '0;
                if (j > i && PRED[j*N+i]) begin
                    if (unit_of(map_hw[j], map_sw[j]) != unit_of(map_hw[i], map_sw[i]))
                        contrib = times[j*TW +: TW];
                    else
                        contrib = raw_v[j];
                end
                if (contrib > raw_v[i])
                    raw_v[i] = contrib;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_out
        assign urgency[g*TW +: TW] = map_hw[g] ? '0 : raw_v[g];
    end

endmodule

// File: rtl/dft_node.sv
module dft_node #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          map_hw,
    input  logic          map_sw,
    input  logic [TW-1:0] exec_time,
    input  logic          deps_ok,
    input  logic [TW-1:0] asap,
    input  logic          grant,
    input  logic          master_busy,
    input  logic          slave_busy,
    output logic          done,
    output logic [TW-1:0] finish,
    output logic [1:0]    state
);
    import dft_pkg::*;

    typedef struct packed {
        logic          done;
        logic [TW-1:0] start;
    } node_s;

    node_s         node_q, node_d;
    unit_e         unit_w;
    logic          idle_w;
    logic          cpu_free_w;
    logic          self_fire_w;
    logic          fire_w;
    task_state_e   state_w;

    always_comb begin
        unit_w      = unit_of(map_hw, map_sw);
        idle_w      = (exec_time == '0);
        cpu_free_w  = (unit_w == U_MASTER) ? !master_busy :
                      (unit_w == U_SLAVE)  ? !slave_busy  : 1'b1;
        self_fire_w = (unit_w == U_FABRIC) || idle_w;
        fire_w      = !node_q.done && deps_ok &&
                      (self_fire_w || (grant && cpu_free_w));

        node_d = node_q;
        if (fire_w) begin
            node_d.done  = 1'b1;
            node_d.start = asap;
        end

        if (node_q.done)
            state_w = ST_STOP;
        else if (!deps_ok)
            state_w = ST_WAIT;
        else if (self_fire_w || cpu_free_w)
            state_w = ST_RUN;
        else
            state_w = ST_READY;
    end

    always_ff @(posedge clk) begin
        if (rst)
            node_q <= '0;
        else
            node_q <= node_d;
    end

    assign done   = node_q.done;
    assign finish = node_q.start + exec_time;
    assign state  = state_w;

endmodule

// File: rtl/dft_graph.sv
module dft_graph #(
    parameter int             N    = 4,
    parameter int             TW   = 16,
    // bit (succ*N + pred) set means task succ depends on task pred;
    // predecessors must carry lower indices than their successors
    parameter logic [N*N-1:0] PRED = 16'h6110
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    task_hw,
    input  logic [N-1:0]    task_sw,
    input  logic [N*TW-1:0] task_time,
    input  logic [N-1:0]    task_grant,
    input  logic            master_busy,
    input  logic            slave_busy,
    output logic [2*N-1:0]  task_state,
    output logic [N*TW-1:0] task_asap,
    output logic [N*TW-1:0] task_urgency,
    output logic [N*TW-1:0] task_finish,
    output logic [N-1:0]    task_done,
    output logic            all_done,
    output logic [TW-1:0]   total_time
);

    logic [N-1:0]  deps_ok_w;
    logic [TW-1:0] asap_w [N];
    logic [TW-1:0] fin_w  [N];
    logic [N-1:0]  done_w;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            deps_ok_w[i] = 1'b1;
            asap_w[i]    = '0;
            for (int j = 0; j < N; j++) begin
                if (PRED[i*N+j]) begin
                    if (!done_w[j])
                        deps_ok_w[i] = 1'b0;
                    if (fin_w[j] > asap_w[i])
                        asap_w[i] = fin_w[j];
                end
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_node
        dft_node #(.TW(TW)) u_node (
            .clk        (clk),
            .rst        (rst),
            .map_hw     (task_hw[g]),
            .map_sw     (task_sw[g]),
            .exec_time  (task_time[g*TW +: TW]),
            .deps_ok    (deps_ok_w[g]),
            .asap       (asap_w[g]),
            .grant      (task_grant[g]),
            .master_busy(master_busy),
            .slave_busy (slave_busy),
            .done       (done_w[g]),
            .finish     (fin_w[g]),
            .state      (task_state[2*g +: 2])
        );
        assign task_asap[g*TW +: TW]   = asap_w[g];
        assign task_finish[g*TW +: TW] = fin_w[g];
    end

    dft_urgency #(.N(N), .TW(TW), .PRED(PRED)) u_urg (
        .map_hw (task_hw),
        .map_sw (task_sw),
        .times  (task_time),
        .urgency(task_urgency)
    );

    always_comb begin
        total_time = '0;
        for (int i = 0; i < N; i++) begin
            if (done_w[i] && fin_w[i] > total_time)
                total_time = fin_w[i];
        end
    end

    assign task_done = done_w;
    assign all_done  = &done_w;

endmodule

// File: rtl/dft_graph_chk.sv
module dft_graph_chk #(
    parameter int             N    = 4,
    parameter int             TW   = 16,
    parameter logic [N*N-1:0] PRED = 16'h6110
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    task_hw,
    input logic [N-1:0]    task_sw,
    input logic [N*TW-1:0] task_time,
    input logic [N-1:0]    task_grant,
    input logic            master_busy,
    input logic            slave_busy,
    input logic [2*N-1:0]  task_state,
    input logic [N*TW-1:0] task_finish,
    input logic [N-1:0]    task_done,
    input logic            all_done,
    input logic [TW-1:0]   total_time
);

    for (genvar g = 0; g < N; g++) begin : g_chk
        localparam logic [N-1:0] PMASK = PRED[g*N +: N];

        AST_FABRIC_NOT_READY: assert property (@(posedge clk) disable iff (rst)
            task_hw[g] |-> task_state[2*g +: 2] != 2'd1); // R5

        AST_DONE_AFTER_DEPS: assert property (@(posedge clk) disable iff (rst)
            $rose(task_done[g]) |-> (($past(task_done) & PMASK) == PMASK)); // R3

        AST_SW_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
            ($rose(task_done[g]) && !$past(task_hw[g]) &&
             ($past(task_time[g*TW +: TW]) != '0))
            |-> ($past(task_grant[g]) &&
                 !$past(task_sw[g] ? master_busy : slave_busy))); // R4

        AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
            task_done[g] |=> task_done[g]); // R2

        AST_TOTAL_COVERS: assert property (@(posedge clk) disable iff (rst)
            all_done |-> total_time >= task_finish[g*TW +: TW]); // R8
    end

endmodule

bind dft_graph dft_graph_chk #(.N(N), .TW(TW), .PRED(PRED)) u_chk (.*);

// File: tb/tb_dft_graph.sv
module tb_dft_graph;

    localparam int N  = 4;
    localparam int TW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    task_hw = '0;
    logic [N-1:0]    task_sw = '0;
    logic [N*TW-1:0] task_time = '0;
    logic [N-1:0]    task_grant = '0;
    logic            master_busy = 1'b0;
    logic            slave_busy = 1'b0;
    logic [2*N-1:0]  task_state;
    logic [N*TW-1:0] task_asap;
    logic [N*TW-1:0] task_urgency;
    logic [N*TW-1:0] task_finish;
    logic [N-1:0]    task_done;
    logic            all_done;
    logic [TW-1:0]   total_time;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // graph: 0->1, 0->2, 1->3, 2->3
    dft_graph #(.N(N), .TW(TW), .PRED(16'h6110)) dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int st(input int i);
        return int'(task_state[2*i +: 2]);
    endfunction
    function automatic int fin(input int i);
        return int'(task_finish[i*TW +: TW]);
    endfunction
    function automatic int asp(input int i);
        return int'(task_asap[i*TW +: TW]);
    endfunction
    function automatic int urg(input int i);
        return int'(task_urgency[i*TW +: TW]);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic setup(input logic [N-1:0] hw, input logic [N-1:0] sw,
                         input int t0, input int t1, input int t2, input int t3);
        task_hw   = hw;
        task_sw   = sw;
        task_time = {TW'(t3), TW'(t2), TW'(t1), TW'(t0)};
        task_grant = '0;
        master_busy = 1'b0;
        slave_busy  = 1'b0;
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        #1;
    endtask

    // T0,T1 master, T2 fabric, T3 slave
    task automatic t_reset_and_urgency();
        setup(4'b0100, 4'b0011, 5, 7, 4, 9);
        chk("R9 done cleared", int'(task_done), 0);
        chk("R9 all_done low", int'(all_done), 0);
        chk("R9 total zero", int'(total_time), 0);
        chk("R5 source task running", st(0), 2);
        chk("R5 dependent task waiting", st(3), 0);
        chk("R6 urgency passed back via same unit", urg(0), 9);
        chk("R6 urgency from other-unit successor", urg(1), 9);
        chk("R6 fabric urgency zero", urg(2), 0);
        chk("R6 no successors", urg(3), 0);
    endtask

    task automatic t_full_schedule();
        setup(4'b0100, 4'b0011, 5, 7, 4, 9);
        chk("R2 asap with no predecessor", asp(0), 0);
        task_grant = 4'b0001;
        tick();
        task_grant = '0;
        chk("R4 granted task done", int'(task_done), 4'b0001);
        chk("R2 finish of T0", fin(0), 5);
        chk("R2 asap of T1", asp(1), 5);
        chk("R5 fabric task running", st(2), 2);
        tick();
        chk("R3 fabric completes without grant, T1 waits for grant", int'(task_done), 4'b0101);
        chk("R2 finish of T2", fin(2), 9);
        task_grant = 4'b0010;
        tick();
        task_grant = '0;
        chk("R2 finish of T1", fin(1), 12);
        chk("R2 asap is max of predecessors", asp(3), 12);
        chk("R8 not all done yet", int'(all_done), 0);
        task_grant = 4'b1000;
        tick();
        task_grant = '0;
        chk("R2 finish of T3", fin(3), 21);
        chk("R8 all done", int'(all_done), 1);
        chk("R8 total time", int'(total_time), 21);
        chk("R5 stopped state", st(3), 3);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R9 reset after run clears done", int'(task_done), 0);
        chk("R9 reset after run clears total", int'(total_time), 0);
    endtask

    task automatic t_busy_and_ignored_grants();
        setup(4'b0100, 4'b0011, 5, 7, 4, 9);
        master_busy = 1'b1;
        #1;
        chk("R5 ready when processor busy", st(0), 1);
        task_grant = 4'b0001;
        tick();
        chk("R4 grant ignored while busy", int'(task_done), 0);
        master_busy = 1'b0;
        slave_busy  = 1'b1;
        task_grant = 4'b1000;
        tick();
        chk("R4 grant to waiting task ignored", int'(task_done), 0);
        task_grant = 4'b0001;
        tick();
        chk("R4 grant accepted when free", int'(task_done), 4'b0001);
        task_grant = 4'b0010;
        tick();
        task_grant = '0;
        chk("R4 T1 and fabric T2 done", int'(task_done), 4'b0111);
        chk("R5 slave task ready while slave busy", st(3), 1);
        tick();
        chk("R4 no completion without grant", int'(task_done), 4'b0111);
    endtask

    task automatic t_all_fabric();
        setup(4'b1111, 4'b1111, 3, 4, 6, 2);
        chk("R1 hw overrides sw, runs without grant", st(0), 2);
        tick();
        chk("R3 first fabric done", int'(task_done), 4'b0001);
        tick();
        chk("R3 parallel fabric tasks same edge", int'(task_done), 4'b0111);
        chk("R2 fabric finish T1", fin(1), 7);
        chk("R2 fabric finish T2", fin(2), 9);
        tick();
        chk("R8 fabric graph total", int'(total_time), 11);
        chk("R8 fabric graph all done", int'(all_done), 1);
    endtask

    // T0 slave, T1 master, T2,T3 slave
    task automatic t_mixed_cpus();
        setup(4'b0000, 4'b0010, 5, 7, 4, 9);
        chk("R1 master vs slave differ for urgency", urg(0), 7);
        chk("R6 same-unit chain with zero urgency", urg(2), 0);
        chk("R6 master to slave successor", urg(1), 9);
    endtask

    task automatic t_zero_time();
        setup(4'b0100, 4'b0011, 5, 0, 4, 9);
        master_busy = 1'b0;
        task_grant = 4'b0001;
        tick();
        task_grant = '0;
        master_busy = 1'b1;
        tick();
        chk("R7 idle task completes without grant", int'(task_done), 4'b0111);
        chk("R7 idle finish equals start", fin(1), 5);
        chk("R2 asap after idle task", asp(3), 9);
        master_busy = 1'b0;
        task_grant = 4'b1000;
        tick();
        task_grant = '0;
        chk("R8 total with idle task", int'(total_time), 18);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_and_urgency();
        t_full_schedule();
        t_busy_and_ignored_grants();
        t_all_fabric();
        t_mixed_cpus();
        t_zero_time();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule